// File: doc/BRIEF.md
# Debug-Pod Reset and Pin-Float Strap Controller

This block is the reset control logic of an in-circuit debug pod that clips over a processor soldered to a board. The pod can only take over the target if the processor keeps all of its pins floating. The processor floats its pins when reset is asserted while certain strap pins are held low. It leaves that float state as soon as it sees a reset without those straps. The controller therefore pulls the strap pins low for every reset, whether the reset comes from the target board or from the debugger. It keeps the straps low for a short programmable time after reset is released, which covers the skew between the processor and the pod seeing the edge.

The controller also decides what a reset raised by the target means for the pod's own processor. If the pod is not executing target code, such a reset has no effect on run control. If the pod is executing and the software mask bit is set, the reset also has no effect. If the pod is executing and the mask is clear, the controller starts a full reset cycle of the pod processor. When the target releases reset, it signals a restart from the reset vector.

A debugger reset request pulls the shared reset wire low through an open-drain enable for a fixed number of cycles. The straps go low one cycle before the wire does.

Top module: `float_reset_ctl`

## Requirements
- R1: After the synchronous reset is released, with the target reset input low, every output is low.
- R2: While the sensed target reset input is high, the strap drive for the current style is high in the same cycle. There is no clock delay from the input to the strap drive.
- R3: Strap style 0 drives only the single address-line strap. Style 1 drives both chip-select straps together (`cs_strap_o` = 2'b11). The two styles are never driven at the same time.
- R4: The style select is captured only at a clock edge where no reset source is active and no strap hold is running. A change made during a reset takes effect only on a later reset.
- R5: The strap drive goes low at the HOLD_CYC-th clock edge after the last edge at which any reset source was active (default 4).
- R6: A rising edge on the debugger request starts a sequence. The strap drives go high after the next edge. The reset drive goes high one edge later and stays high for exactly DBG_LEN cycles (default 16).
- R7: The open-drain reset drive is never active unless a strap drive is active.
- R8: A rising edge on the debugger request while a debugger sequence is in progress is ignored. The sequence neither lengthens nor repeats.
- R9: A target reset while `running_i` is low gives no core reset pulse and no restart pulse. The straps are still driven.
- R10: A target reset while running with `mask_i` high gives no core reset pulse and no restart pulse.
- R11: A target reset while running with the mask clear gives a one-cycle `core_rst_o` pulse at the third clock edge after the input rises. It gives a one-cycle `restart_o` pulse at the third clock edge after the input falls.
- R12: A target reset never turns on the open-drain reset drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_rst_i | input | 1 | Sensed target reset wire, 1 = reset asserted |
| mask_i | input | 1 | Software mask; 1 = ignore target reset for run control |
| running_i | input | 1 | 1 = pod is executing target code |
| dbg_req_i | input | 1 | Debugger reset request; a rising edge starts a sequence |
| style_sel_i | input | 1 | Strap style: 0 = address-line strap, 1 = chip-select pair |
| rst_pull_o | output | 1 | Open-drain pull-low enable for the reset wire |
| addr_strap_o | output | 1 | Pull-low enable for the address-line strap |
| cs_strap_o | output | 2 | Pull-low enables for the upper and lower chip-select straps |
| core_rst_o | output | 1 | One-cycle pulse that starts the pod processor reset cycle |
| restart_o | output | 1 | One-cycle pulse: resume from the reset vector |

## Verification
The strap drives follow the target reset input with no clock delay. `core_rst_o` and `restart_o` are due three edges after the input rises and three edges after it falls, because two synchronizer flops and one decision flop lie on that path. The debugger reset drive is due two edges after the request rises, and each strap is released HOLD_CYC edges after its last active source. Every stimulus task records the absolute cycle at which it changes an input. It queues each expected value with the exact cycle number derived from these latencies, and it also queues the cycles just before and after each pulse. The monitor samples two nanoseconds after each rising edge and compares only the entries due in that cycle.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic {
    STRAP_ADDR = 1'b0,
    STRAP_CS   = 1'b1
  } strap_style_e;
endpackage

// File: rtl/frc_sync.sv
module frc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/frc_dbg_seq.sv
module frc_dbg_seq #(
  parameter int unsigned DBG_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic pre_o,
  output logic drv_o
);
  localparam int unsigned CW = (DBG_LEN > 2) ? $clog2(DBG_LEN) : 1;

  logic          req_q;
  logic [CW-1:0] cnt;
  logic          req_edge;

  assign req_edge = req_i & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      pre_o <= 1'b0;
      drv_o <= 1'b0;
      cnt   <= '0;
    end else begin
      req_q <= req_i;
      if (pre_o) begin
        pre_o <= 1'b0;
        drv_o <= 1'b1;
        cnt   <= CW'(DBG_LEN - 1);
      end else if (drv_o) begin
        if (cnt == '0) drv_o <= 1'b0;
        else           cnt   <= cnt - 1'b1;
      end else if (req_edge) begin
        pre_o <= 1'b1;
      end
    end
  end

  // R6: the drive only starts after a strap lead-in cycle
  p_lead_in_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_o) |-> $past(pre_o));
  // R8: a request during a sequence does not re-enter the lead-in
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    drv_o |=> !pre_o);
endmodule

// File: rtl/frc_strap_hold.sv
module frc_strap_hold
  import frc_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         src_i,
  input  logic         style_sel_i,
  output logic         strap_on_o,
  output strap_style_e style_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] hold_cnt;

  assign strap_on_o = src_i | (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      style_o  <= STRAP_ADDR;
    end else begin
      if (src_i)               hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (!strap_on_o)         style_o  <= strap_style_e'(style_sel_i);
    end
  end

  // R4: the style is frozen while a reset or hold is running
  p_style_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    strap_on_o |=> $stable(style_o));
  // R5: the hold never ends while a source is still active
  p_hold_covers_src_r5: assert property (@(posedge clk) disable iff (rst)
    src_i |=> strap_on_o);
endmodule

// File: rtl/frc_run_ctl.sv
module frc_run_ctl (
  input  logic clk,
  input  logic rst,
  input  logic tgt_s_i,
  input  logic running_i,
  input  logic mask_i,
  output logic core_rst_o,
  output logic restart_o
);
  logic tgt_q;
  logic pending;
  logic rise;
  logic accept;

  assign rise   = tgt_s_i & ~tgt_q;
  assign accept = rise & running_i & ~mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q      <= 1'b0;
      pending    <= 1'b0;
      core_rst_o <= 1'b0;
      restart_o  <= 1'b0;
    end else begin
      tgt_q      <= tgt_s_i;
      core_rst_o <= 1'b0;
      restart_o  <= 1'b0;
      if (accept) begin
        core_rst_o <= 1'b1;
        pending    <= 1'b1;
      end else if (pending && !tgt_s_i) begin
        restart_o  <= 1'b1;
        pending    <= 1'b0;
      end
    end
  end

  // R11: each pulse lasts a single cycle
  p_core_single_r11: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |=> !core_rst_o);
  p_restart_single_r11: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);
  // R9 / R10: a filtered reset edge never starts the core
  p_filtered_r9_r10: assert property (@(posedge clk) disable iff (rst)
    (rise && (!running_i || mask_i)) |=> !core_rst_o);
endmodule

// File: rtl/float_reset_ctl.sv
module float_reset_ctl
  import frc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned DBG_LEN     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tgt_rst_i,
  input  logic       mask_i,
  input  logic       running_i,
  input  logic       dbg_req_i,
  input  logic       style_sel_i,
  output logic       rst_pull_o,
  output logic       addr_strap_o,
  output logic [1:0] cs_strap_o,
  output logic       core_rst_o,
  output logic       restart_o
);
  logic         tgt_s;
  logic         dbg_pre;
  logic         dbg_drv;
  logic         strap_on;
  strap_style_e style_q;

  frc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (tgt_rst_i), .q_o (tgt_s)
  );

  frc_dbg_seq #(.DBG_LEN(DBG_LEN)) u_dbg (
    .clk (clk), .rst (rst), .req_i (dbg_req_i),
    .pre_o (dbg_pre), .drv_o (dbg_drv)
  );

  frc_strap_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk (clk), .rst (rst),
    .src_i (tgt_rst_i | dbg_pre | dbg_drv),
    .style_sel_i (style_sel_i),
    .strap_on_o (strap_on), .style_o (style_q)
  );

  frc_run_ctl u_run (
    .clk (clk), .rst (rst), .tgt_s_i (tgt_s),
    .running_i (running_i), .mask_i (mask_i),
    .core_rst_o (core_rst_o), .restart_o (restart_o)
  );

  assign rst_pull_o   = dbg_drv;
  assign addr_strap_o = strap_on & (style_q == STRAP_ADDR);
  assign cs_strap_o   = {2{strap_on & (style_q == STRAP_CS)}};

  // R7: reset wire is never pulled without the straps
  p_pull_has_strap_r7: assert property (@(posedge clk) disable iff (rst)
    rst_pull_o |-> (addr_strap_o || (cs_strap_o != 2'b00)));
  // R2: a sensed target reset always carries a strap
  p_tgt_strap_r2: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_i |-> (addr_strap_o || (cs_strap_o != 2'b00)));
  // R3: one strap style at a time, chip-selects move as a pair
  p_one_style_r3: assert property (@(posedge clk) disable iff (rst)
    !(addr_strap_o && (cs_strap_o != 2'b00)) && (cs_strap_o != 2'b01) && (cs_strap_o != 2'b10));
endmodule

// File: tb/test_float_reset_ctl.sv
module test_float_reset_ctl;
  localparam int HOLD = 4;
  localparam int LEN  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tgt_rst_i = 1'b0, mask_i = 1'b0, running_i = 1'b0;
  logic dbg_req_i = 1'b0, style_sel_i = 1'b0;
  logic rst_pull_o, addr_strap_o, core_rst_o, restart_o;
  logic [1:0] cs_strap_o;

  always #4 clk = ~clk;

  float_reset_ctl #(.SYNC_STAGES(2), .HOLD_CYC(HOLD), .DBG_LEN(LEN)) i_float_reset_ctl (
    .clk, .rst, .tgt_rst_i, .mask_i, .running_i, .dbg_req_i, .style_sel_i,
    .rst_pull_o, .addr_strap_o, .cs_strap_o, .core_rst_o, .restart_o
  );

  typedef struct { int cyc; int sig; logic [1:0] val; string tag; } item_t;
  item_t sb_q[$];
  int cnt = 0, checks = 0, fails = 0;
  bit done = 0;

  task automatic expect_at(int cyc, int sig, logic [1:0] val, string tag);
    item_t it;
    it.cyc = cyc; it.sig = sig; it.val = val; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // sig ids: 0 pull, 1 addr strap, 2 cs straps, 3 core reset, 4 restart
  task automatic expect_strap(int cyc, bit on, bit style, string tag);
    expect_at(cyc, 1, {1'b0, on & ~style}, tag);
    expect_at(cyc, 2, {2{on & style}}, tag);
  endtask

  function automatic logic [1:0] sample(int sig);
    case (sig)
      0: return {1'b0, rst_pull_o};
      1: return {1'b0, addr_strap_o};
      2: return cs_strap_o;
      3: return {1'b0, core_rst_o};
      default: return {1'b0, restart_o};
    endcase
  endfunction

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cnt++;
      #2;
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].cyc == cnt) begin
          checks++;
          if (sample(sb_q[i].sig) !== sb_q[i].val) begin
            fails++;
            $display("FAIL %s cycle %0d sig %0d: actual %b expected %b",
                     sb_q[i].tag, cnt, sb_q[i].sig, sample(sb_q[i].sig), sb_q[i].val);
          end
          sb_q.delete(i);
        end
      end
    end
  end

  task automatic tgt_reset(int len, bit run, bit msk, bit style, bit new_style, string tag);
    int c;
    bit acc;
    @(negedge clk);
    c = cnt;
    acc = run & ~msk;
    running_i = run; mask_i = msk; tgt_rst_i = 1'b1;
    expect_strap(c + 1, 1'b1, style, "R2");
    expect_strap(c + len, 1'b1, style, "R3");
    expect_strap(c + len + HOLD - 1, 1'b1, style, "R5");
    expect_strap(c + len + HOLD, 1'b0, style, "R5");
    expect_at(c + 1, 0, 2'b00, "R12");
    expect_at(c + len, 0, 2'b00, "R12");
    expect_at(c + 2, 3, 2'b00, tag);
    expect_at(c + 3, 3, {1'b0, acc}, tag);
    expect_at(c + 4, 3, 2'b00, tag);
    expect_at(c + len + 2, 4, 2'b00, tag);
    expect_at(c + len + 3, 4, {1'b0, acc}, tag);
    expect_at(c + len + 4, 4, 2'b00, tag);
    repeat (2) @(negedge clk);
    style_sel_i = new_style;
    repeat (len - 2) @(negedge clk);
    tgt_rst_i = 1'b0;
    repeat (HOLD + 6) @(negedge clk);
  endtask

  task automatic dbg_reset(bit style);
    int c;
    @(negedge clk);
    c = cnt;
    dbg_req_i = 1'b1;
    expect_strap(c + 1, 1'b1, style, "R6");
    expect_at(c + 1, 0, 2'b00, "R6");
    expect_at(c + 2, 0, 2'b01, "R6");
    expect_strap(c + 2, 1'b1, style, "R7");
    expect_at(c + 1 + LEN, 0, 2'b01, "R6");
    expect_at(c + 2 + LEN, 0, 2'b00, "R6");
    expect_at(c + 3 + LEN, 0, 2'b00, "R8");
    expect_strap(c + 1 + LEN + HOLD, 1'b1, style, "R5");
    expect_strap(c + 2 + LEN + HOLD, 1'b0, style, "R5");
    expect_strap(c + 4 + LEN + HOLD, 1'b0, style, "R8");
    expect_at(c + 3, 3, 2'b00, "R12");
    repeat (2) @(negedge clk);
    dbg_req_i = 1'b0;
    repeat (2) @(negedge clk);
    dbg_req_i = 1'b1;
    repeat (2) @(negedge clk);
    dbg_req_i = 1'b0;
    repeat (LEN + HOLD + 4) @(negedge clk);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    c = cnt;
    for (int s = 0; s < 5; s++) expect_at(c + 1, s, 2'b00, "R1");
    repeat (3) @(negedge clk);
    tgt_reset(6, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    tgt_reset(6, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
    tgt_reset(8, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
    // style change above must apply only now (R4)
    tgt_reset(7, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
    dbg_reset(1'b1);
    style_sel_i = 1'b0;
    repeat (2) @(negedge clk);
    dbg_reset(1'b0);
    tgt_reset(4, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule